// File: doc/BRIEF.md
# Page-Mode Burst DRAM Sequencer

This block sits between a host that asks for bursts of words and a DRAM array whose address pins carry the row and the column at different times. The host gives one request: a row, a first column, a word count and a direction. The sequencer opens the row once by driving the row address with the row strobe. After a fixed row-to-column delay it issues one column strobe per clock. The column address starts at the requested column and goes up by one on each beat. Each beat moves one data word into or out of the array.

The row strobe stays high for the whole burst, so the open row is never re-addressed. A burst that would run past the last column of the row stops at that column and never continues into another row. After the last beat the row strobe drops. The block then stays in precharge for a fixed number of cycles before it can accept a new request. Read words come back to the host with a one-cycle valid pulse each. Write words are taken from the host on every write beat.

Top module: `burst_dram_seq`

## Requirements
- R1: After reset, reqReady is 1 and rowStrobe, colStrobe and rdValid are 0.
- R2: A burst begins with rowStrobe high and colStrobe low for exactly T_RCD cycles while dramAddr carries the requested row.
- R3: rowStrobe stays high from the opening cycle until the last beat, for T_RCD plus beat-count cycles, and colStrobe is never high while rowStrobe is low.
- R4: A request is taken on a clock edge where reqValid and reqReady are both 1. reqReady is 1 only in the idle state, so it is never high together with rowStrobe.
- R5: During a burst, dramAddr on the first column strobe equals reqCol and increases by exactly one on each following beat. The number of beats equals reqLen when the burst fits in the row.
- R6: When reqCol + reqLen exceeds 2^COL_W, the burst is cut at column 2^COL_W-1, giving 2^COL_W - reqCol beats. The column address never wraps back to 0 inside a burst.
- R7: After the last beat, rowStrobe is low and reqReady stays 0 for exactly T_RP cycles of precharge. reqReady is then 1 again.
- R8: On a read (reqWrite=0), each column beat produces rdValid high for one cycle, one cycle later, with rdData equal to the array word at that column.
- R9: On a write (reqWrite=1), dramWe is high exactly on the column beats. dramDout carries wrData and wrTake pulses once per beat, so the array word at each column becomes the host word of that beat.
- R10: A request with reqLen = 0 is accepted and does nothing: no strobe is raised and reqReady stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqRow | input | ROW_W | Row to open |
| reqCol | input | COL_W | First column of the burst |
| reqLen | input | COL_W+1 | Requested number of words |
| wrData | input | DATA_W | Host write word for the current beat |
| wrTake | output | 1 | wrData is consumed this cycle |
| rdData | output | DATA_W | Returned read word |
| rdValid | output | 1 | rdData is valid this cycle |
| rowStrobe | output | 1 | Row strobe, active high |
| colStrobe | output | 1 | Column strobe, active high |
| dramWe | output | 1 | Array write enable for the current beat |
| dramAddr | output | max(ROW_W,COL_W) | Shared row/column address lines |
| dramDout | output | DATA_W | Write data to the array |
| dramDin | input | DATA_W | Read data from the array, combinational on address |

## Verification
Directed bursts cover a full-row write from column 0, a read back of that row, a burst that starts near the end of the row and must be cut short, a single beat at the last column, and a zero-length request. Together these separate correct truncation from wrapping or from an extra or missing beat. Seeded random requests mix directions, rows, start columns and lengths, including lengths past the row end. Each read is compared with a shadow copy of the array that the bench updates from its own writes, so a lost write, a wrong column step or a wrong row all show up as data mismatches. For every request the bench also counts the row-to-column delay, the held row strobe and the precharge length, which catches timing changes that would not disturb the data.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_BURST = 2'd2,
    ST_PRE   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic load;     // capture the request fields
    logic advance;  // step column, count down beats
    logic selRow;   // address lines carry the row
    logic rowOn;    // row strobe
    logic colOn;    // column strobe
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_RP  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lenZero,
  input  logic        lastBeat,
  output seqStrobes_t strb,
  output logic        reqReady
);
  localparam int TMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TMR_W = $clog2(TMAX + 1);

  seqState_t         state, stateNxt;
  logic [TMR_W-1:0]  timer, timerNxt;

  always_comb begin
    stateNxt = state;
    timerNxt = timer;
    strb     = '0;
    reqReady = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid && !lenZero) begin
          strb.load = 1'b1;
          stateNxt  = ST_ACT;
          timerNxt  = TMR_W'(T_RCD - 1);
        end
      end
      ST_ACT: begin
        strb.rowOn  = 1'b1;
        strb.selRow = 1'b1;
        if (timer == '0) stateNxt = ST_BURST;
        else             timerNxt = timer - 1'b1;
      end
      ST_BURST: begin
        strb.rowOn   = 1'b1;
        strb.colOn   = 1'b1;
        strb.advance = 1'b1;
        if (lastBeat) begin
          stateNxt = ST_PRE;
          timerNxt = TMR_W'(T_RP - 1);
        end
      end
      ST_PRE: begin
        if (timer == '0) stateNxt = ST_IDLE;
        else             timerNxt = timer - 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      state <= stateNxt;
      timer <= timerNxt;
    end
  end

  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !lenZero |=> strb.rowOn);  // R4
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    strb.colOn && lastBeat |=> !strb.rowOn && !reqReady);  // R7
endmodule

// File: rtl/burst_seq_dpath.sv
module burst_seq_dpath
  import burst_seq_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [COL_W:0]    reqLen,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] dramDin,
  output logic              lenZero,
  output logic              lastBeat,
  output logic              rowStrobe,
  output logic              colStrobe,
  output logic              dramWe,
  output logic [ADDR_W-1:0] dramAddr,
  output logic [DATA_W-1:0] dramDout,
  output logic              wrTake,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int LEN_W = COL_W + 1;
  localparam int COLS  = 1 << COL_W;

  logic [ROW_W-1:0] rowReg;
  logic [COL_W-1:0] colReg;
  logic [LEN_W-1:0] cntReg, avail, clampLen;
  logic             wrReg;

  assign avail    = LEN_W'(COLS) - {1'b0, reqCol};
  assign clampLen = (reqLen > avail) ? avail : reqLen;
  assign lenZero  = (reqLen == '0);
  assign lastBeat = (cntReg == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
      cntReg <= '0;
      wrReg  <= 1'b0;
    end else if (strb.load) begin
      rowReg <= reqRow;
      colReg <= reqCol;
      cntReg <= clampLen;
      wrReg  <= reqWrite;
    end else if (strb.advance) begin
      colReg <= colReg + 1'b1;
      cntReg <= cntReg - 1'b1;
    end
  end

  assign rowStrobe = strb.rowOn;
  assign colStrobe = strb.colOn;
  assign dramAddr  = strb.selRow ? ADDR_W'(rowReg) : ADDR_W'(colReg);
  assign dramWe    = strb.colOn && wrReg;
  assign wrTake    = strb.colOn && wrReg;
  assign dramDout  = wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.colOn && !wrReg;
      if (strb.colOn && !wrReg) rdData <= dramDin;
    end
  end

  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe |-> rowStrobe);  // R3
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe && $past(colStrobe) |-> dramAddr == $past(dramAddr) + 1'b1);  // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe && $past(colStrobe) |-> dramAddr != '0);  // R6
  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rowStrobe) |=> !rowStrobe);  // R7
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(colStrobe && !dramWe));  // R8
endmodule

// File: rtl/burst_dram_seq.sv
module burst_dram_seq
  import burst_seq_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 3,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [COL_W:0]    reqLen,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrTake,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rowStrobe,
  output logic              colStrobe,
  output logic              dramWe,
  output logic [ADDR_W-1:0] dramAddr,
  output logic [DATA_W-1:0] dramDout,
  input  logic [DATA_W-1:0] dramDin
);
  seqStrobes_t strb;
  logic        lenZero, lastBeat;

  burst_seq_ctrl #(.T_RCD(T_RCD), .T_RP(T_RP)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lenZero(lenZero),
    .lastBeat(lastBeat), .strb(strb), .reqReady(reqReady)
  );

  burst_seq_dpath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite), .reqRow(reqRow),
    .reqCol(reqCol), .reqLen(reqLen), .wrData(wrData), .dramDin(dramDin),
    .lenZero(lenZero), .lastBeat(lastBeat), .rowStrobe(rowStrobe),
    .colStrobe(colStrobe), .dramWe(dramWe), .dramAddr(dramAddr),
    .dramDout(dramDout), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/test_burst_dram_seq.sv
`timescale 1ns/1ps
module test_burst_dram_seq;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8, T_RCD = 2, T_RP = 3;
  localparam int ADDR_W = 4;
  localparam int ROWS = 1 << ROW_W, COLS = 1 << COL_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic [COL_W:0]   reqLen = '0;
  logic [DATA_W-1:0] wrData, rdData, dramDout, dramDin;
  logic reqReady, wrTake, rdValid, rowStrobe, colStrobe, dramWe;
  logic [ADDR_W-1:0] dramAddr;

  always #4 clk = ~clk;

  burst_dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_RP(T_RP))
  i_burst_dram_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .reqLen(reqLen),
    .wrData(wrData), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .rowStrobe(rowStrobe), .colStrobe(colStrobe), .dramWe(dramWe),
    .dramAddr(dramAddr), .dramDout(dramDout), .dramDin(dramDin)
  );

  // behavioural array
  logic [DATA_W-1:0] arr [ROWS][COLS];
  logic [DATA_W-1:0] refMem [ROWS][COLS];
  logic [ROW_W-1:0] openRow = '0;
  logic mRowPrev = 1'b0;
  assign dramDin = arr[openRow][dramAddr[COL_W-1:0]];

  int wrCnt = 0;
  logic [DATA_W-1:0] wrBase = '0;
  assign wrData = wrBase + DATA_W'(wrCnt);

  always @(posedge clk) begin
    mRowPrev <= rowStrobe;
    if (rowStrobe && !mRowPrev) openRow <= dramAddr[ROW_W-1:0];
    if (colStrobe && dramWe) arr[openRow][dramAddr[COL_W-1:0]] <= dramDout;
    if (wrTake) wrCnt <= wrCnt + 1;
  end

  // monitor
  int beats, rds, actCnt, preCnt, rowHigh, addrBad, rowAddrBad, weBad, colNoRow, rdyBad;
  int curRow, curCol, curWrite;
  logic [DATA_W-1:0] rdBuf [COLS];
  always @(negedge clk) if (rstN) begin
    if (rowStrobe) rowHigh++;
    if (rowStrobe && !colStrobe) begin
      actCnt++;
      if (int'(dramAddr) != curRow) rowAddrBad++;
    end
    if (colStrobe) begin
      if (!rowStrobe) colNoRow++;
      if (int'(dramAddr) != curCol + beats) addrBad++;
      if (int'(dramWe) != curWrite) weBad++;
      beats++;
    end
    if (rdValid) begin
      if (rds < COLS) rdBuf[rds] = rdData;
      rds++;
    end
    if (!rowStrobe && !reqReady) preCnt++;
    if (reqReady && rowStrobe) rdyBad++;
  end

  int tests = 0, fails = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expBeats(int col, int len);
    return (col + len > COLS) ? COLS - col : len;
  endfunction

  task automatic doReq(bit w, int row, int col, int len, int base);
    int n;
    n = expBeats(col, len);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    curRow = row; curCol = col; curWrite = w;
    beats = 0; rds = 0; actCnt = 0; preCnt = 0; rowHigh = 0;
    addrBad = 0; rowAddrBad = 0; weBad = 0; colNoRow = 0; rdyBad = 0;
    wrBase = DATA_W'(base); wrCnt = 0;
    reqValid = 1'b1; reqWrite = w;
    reqRow = ROW_W'(row); reqCol = COL_W'(col); reqLen = (COL_W+1)'(len);
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
    repeat (2) @(negedge clk);
    if (n == 0) begin
      chk(beats == 0 && actCnt == 0 && rowHigh == 0, "R10 zero-length raised strobes", beats + actCnt, 0);
      chk(reqReady == 1'b1, "R10 ready after zero-length", int'(reqReady), 1);
      return;
    end
    if (col + len > COLS) chk(beats == n, "R6 truncated beat count", beats, n);
    else                  chk(beats == n, "R5 beat count", beats, n);
    chk(actCnt == T_RCD, "R2 row-to-column cycles", actCnt, T_RCD);
    chk(rowAddrBad == 0, "R2 row address", rowAddrBad, 0);
    chk(rowHigh == T_RCD + n && colNoRow == 0, "R3 row strobe held", rowHigh, T_RCD + n);
    chk(addrBad == 0, "R5 column sequence", addrBad, 0);
    chk(rdyBad == 0, "R4 ready while busy", rdyBad, 0);
    chk(preCnt == T_RP, "R7 precharge cycles", preCnt, T_RP);
    chk(weBad == 0, "R9 write enable per beat", weBad, 0);
    if (w) begin
      chk(wrCnt == n, "R9 wrTake count", wrCnt, n);
      for (int i = 0; i < n; i++) begin
        refMem[row][col+i] = DATA_W'(base + i);
        chk(arr[row][col+i] == refMem[row][col+i], "R9 array word",
            int'(arr[row][col+i]), int'(refMem[row][col+i]));
      end
    end else begin
      chk(rds == n, "R8 read word count", rds, n);
      for (int i = 0; i < n && i < rds; i++)
        chk(rdBuf[i] == refMem[row][col+i], "R8 read data",
            int'(rdBuf[i]), int'(refMem[row][col+i]));
    end
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        arr[r][c] = '0;
        refMem[r][c] = '0;
      end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", int'(reqReady), 1);
    chk(!rowStrobe && !colStrobe && !rdValid, "R1 strobes idle after reset",
        int'(rowStrobe) + int'(colStrobe) + int'(rdValid), 0);
    // directed corners
    doReq(1'b1, 5, 0, COLS, 8'h10);     // full row write
    doReq(1'b0, 5, 0, COLS, 0);         // full row read
    doReq(1'b1, 9, 14, 8, 8'hA0);       // truncated write
    doReq(1'b0, 9, 12, 10, 0);          // truncated read
    doReq(1'b1, 15, 15, 1, 8'h77);      // last column single
    doReq(1'b0, 15, 15, 1, 0);
    doReq(1'b0, 3, 4, 0, 0);            // zero length
    doReq(1'b1, 0, 7, 1, 8'h3C);
    doReq(1'b0, 0, 6, 3, 0);
    // seeded random
    for (int k = 0; k < 60; k++) begin
      doReq(1'($urandom % 2), int'($urandom % ROWS), int'($urandom % COLS),
            int'($urandom % 20), int'($urandom % 256));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule